// File: doc/BRIEF.md
# GPIO Group Interrupt Combiner

This block watches a bank of general-purpose input pins and forms interrupt requests from groups of them. Each group holds up to eight member slots. Every slot names one input pin and carries its own polarity bit, which says whether that pin counts as active when high or when low. A group combines its members in one of two ways. In any-member mode one active member is enough. In all-members mode every counted member must be active. Only the first N slots are counted, and N is programmable.

A group works either on the level of its combined condition or on its false-to-true transitions. When the group condition fires, a sticky group flag goes up and drives that group's request output. A per-slot cause word records which members were active at that moment. A software clear pulse drops the flag and the cause word. The default build provides two independent groups. Each group has its own configuration, clear input, request output and cause word.

The pins pass through a two-flop synchronizer. Each group's configuration is registered inside the block, so the request output is fully registered.

Top module: `gpio_grp_irq_top`

## Requirements
- R1: While reset is held and right after it is released, every request output and every cause bit is 0.
- R2: In any-member mode (combine bit 0), the group flag is set when at least one counted member is active.
- R3: In all-members mode (combine bit 1), the group flag is set only when every counted member is active.
- R4: A slot's polarity bit of 1 makes its pin active when high. A polarity bit of 0 makes it active when low.
- R5: Slots at index count or above have no effect on the group. A count of 0 never raises the flag. Slot s of group g reads the pin index in `cfg_sel[(g*8+s)*4 +: 4]`.
- R6: In edge mode (edge bit 1), the flag is set only in the cycle after the condition changes from false to true. A clear issued while the condition stays true leaves the flag low.
- R7: In level mode (edge bit 0), the flag is set in every cycle the condition holds, so a clear issued during that time has no visible effect.
- R8: When the flag is set, the cause bit of each counted member that is active at that moment is set. Cause bit s belongs to slot s. A cause bit is never 1 while the flag is 0.
- R9: A one-cycle pulse on a group's clear input drops that group's flag and cause word when no new set event occurs in the same cycle.
- R10: Groups are independent. An event on one group's members, or a clear of one group, leaves the other group's request and cause word unchanged.
- R11: A pin change that is driven before rising edge k appears on the request output after rising edge k+3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpio_in | input | NPIN (16) | Asynchronous input pins |
| cfg_sel | input | NGRP*MAXM*SELW (64) | Pin index per slot per group |
| cfg_pol | input | NGRP*MAXM (16) | Polarity per slot, 1 means active high |
| cfg_cnt | input | NGRP*CNTW (8) | Number of counted slots per group |
| cfg_and | input | NGRP (2) | 1 selects all-members mode, 0 selects any-member mode |
| cfg_edge | input | NGRP (2) | 1 selects edge mode, 0 selects level mode |
| clr | input | NGRP (2) | Per-group clear pulse |
| irq_o | output | NGRP (2) | Per-group interrupt request |
| cause_o | output | NGRP*MAXM (16) | Per-group cause bits, one per slot |

## Verification
The assertions assume that the configuration of a group stays constant while events are being judged. They also assume that a clear is a single-cycle pulse, and that pins change slowly compared with the clock. The edge-mode and level-mode properties compare the flag with the previous cycle's mode bit, so a mode switch is only safe while the group is quiet. For that reason the stimulus reprograms a group first, then waits several cycles for the registered configuration to settle, and only then clears the group and drives any member pins. Each pin is held for at least six cycles, and each clear is exactly one cycle wide.

// File: rtl/gpio_grp_pkg.sv
package gpio_grp_pkg;

  // Returns a mask with the lowest n bits set (n saturates at 32).
  function automatic logic [31:0] low_mask(input int unsigned n);
    logic [31:0] m;
    for (int i = 0; i < 32; i++) begin
      m[i] = (i < n);
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_member_sel.sv
module gpio_member_sel
  import gpio_grp_pkg::*;
#(
  parameter int NPIN = 16,
  parameter int MAXM = 8,
  parameter int SELW = 4,
  parameter int CNTW = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NPIN-1:0]      pins_i,
  input  logic [MAXM*SELW-1:0] sel_i,
  input  logic [MAXM-1:0]      pol_i,
  input  logic [CNTW-1:0]      cnt_i,
  input  logic                 and_i,
  input  logic                 edge_i,
  output logic [MAXM-1:0]      act_o,
  output logic [MAXM-1:0]      valid_o,
  output logic                 and_o,
  output logic                 edge_o
);
  logic [MAXM*SELW-1:0] sel_q;
  logic [MAXM-1:0]      pol_q;
  logic [CNTW-1:0]      cnt_q;
  logic                 and_q, edge_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= '0;
      pol_q  <= '0;
      cnt_q  <= '0;
      and_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      sel_q  <= sel_i;
      pol_q  <= pol_i;
      cnt_q  <= cnt_i;
      and_q  <= and_i;
      edge_q <= edge_i;
    end
  end

  logic [31:0]     mask_full;
  logic [MAXM-1:0] valid_c;
  logic [MAXM-1:0] act_c;

  always_comb begin
    mask_full = low_mask(32'(cnt_q));
    valid_c   = mask_full[MAXM-1:0];
  end

  for (genvar m = 0; m < MAXM; m++) begin : g_slot
    logic [SELW-1:0] idx;
    logic            raw;
    assign idx = sel_q[m*SELW +: SELW];
    assign raw = (32'(idx) < NPIN) ? pins_i[idx] : 1'b0;
    assign act_c[m] = (raw ~^ pol_q[m]) & valid_c[m];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_o   <= '0;
      valid_o <= '0;
      and_o   <= 1'b0;
      edge_o  <= 1'b0;
    end else begin
      act_o   <= act_c;
      valid_o <= valid_c;
      and_o   <= and_q;
      edge_o  <= edge_q;
    end
  end
endmodule

// File: rtl/gpio_grp_core.sv
module gpio_grp_core #(
  parameter int MAXM = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MAXM-1:0] act_i,
  input  logic [MAXM-1:0] valid_i,
  input  logic            and_i,
  input  logic            edge_i,
  input  logic            clr_i,
  output logic            flag_o,
  output logic [MAXM-1:0] cause_o
);
  logic            cond, cond_prev_q, set_evt;
  logic            flag_q;
  logic [MAXM-1:0] cause_q;

  always_comb begin
    if (valid_i == '0)
      cond = 1'b0;
    else if (and_i)
      cond = &(act_i | ~valid_i);
    else
      cond = |(act_i & valid_i);
    set_evt = edge_i ? (cond & ~cond_prev_q) : cond;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_prev_q <= 1'b0;
      flag_q      <= 1'b0;
      cause_q     <= '0;
    end else begin
      cond_prev_q <= cond;
      flag_q      <= set_evt | (flag_q & ~clr_i);
      cause_q     <= (clr_i ? '0 : cause_q) | (set_evt ? (act_i & valid_i) : '0);
    end
  end

  assign flag_o  = flag_q;
  assign cause_o = cause_q;

  assert_edge_rise_only_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag_q) && $past(edge_i)) |-> ($past(cond) && !$past(cond_prev_q)));

  assert_level_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!edge_i && cond) |=> flag_q);

  assert_clear_drops_R9: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_evt) |=> (!flag_q && cause_q == '0));

  assert_cause_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (cause_q != '0) |-> flag_q);

  assert_rise_has_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> (cause_q != '0));

  assert_empty_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (valid_i == '0) |=> !$rose(flag_q));
endmodule

// File: rtl/gpio_grp_irq_top.sv
module gpio_grp_irq_top #(
  parameter int NPIN = 16,
  parameter int NGRP = 2,
  parameter int MAXM = 8,
  localparam int SELW = (NPIN > 1) ? $clog2(NPIN) : 1,
  localparam int CNTW = $clog2(MAXM + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPIN-1:0]           gpio_in,
  input  logic [NGRP*MAXM*SELW-1:0] cfg_sel,
  input  logic [NGRP*MAXM-1:0]      cfg_pol,
  input  logic [NGRP*CNTW-1:0]      cfg_cnt,
  input  logic [NGRP-1:0]           cfg_and,
  input  logic [NGRP-1:0]           cfg_edge,
  input  logic [NGRP-1:0]           clr,
  output logic [NGRP-1:0]           irq_o,
  output logic [NGRP*MAXM-1:0]      cause_o
);
  logic [NPIN-1:0] pins_s;

  gpio_sync #(.W(NPIN)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (gpio_in),
    .q_o (pins_s)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [MAXM-1:0] act, valid;
    logic            and_m, edge_m;

    gpio_member_sel #(
      .NPIN(NPIN), .MAXM(MAXM), .SELW(SELW), .CNTW(CNTW)
    ) u_sel (
      .clk     (clk),
      .rst     (rst),
      .pins_i  (pins_s),
      .sel_i   (cfg_sel[g*MAXM*SELW +: MAXM*SELW]),
      .pol_i   (cfg_pol[g*MAXM +: MAXM]),
      .cnt_i   (cfg_cnt[g*CNTW +: CNTW]),
      .and_i   (cfg_and[g]),
      .edge_i  (cfg_edge[g]),
      .act_o   (act),
      .valid_o (valid),
      .and_o   (and_m),
      .edge_o  (edge_m)
    );

    gpio_grp_core #(.MAXM(MAXM)) u_core (
      .clk     (clk),
      .rst     (rst),
      .act_i   (act),
      .valid_i (valid),
      .and_i   (and_m),
      .edge_i  (edge_m),
      .clr_i   (clr[g]),
      .flag_o  (irq_o[g]),
      .cause_o (cause_o[g*MAXM +: MAXM])
    );
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (irq_o == '0 && cause_o == '0));
endmodule

// File: tb/sim_gpio_grp_irq_top.sv
`timescale 1ns/1ps
module sim_gpio_grp_irq_top;
  localparam int NPIN = 16;
  localparam int NGRP = 2;
  localparam int MAXM = 8;
  localparam int SELW = 4;
  localparam int CNTW = 4;

  logic                      clk = 1'b0;
  logic                      rst = 1'b1;
  logic [NPIN-1:0]           gpio = '0;
  logic [NGRP*MAXM*SELW-1:0] cfg_sel = '0;
  logic [NGRP*MAXM-1:0]      cfg_pol = '0;
  logic [NGRP*CNTW-1:0]      cfg_cnt = '0;
  logic [NGRP-1:0]           cfg_and = '0;
  logic [NGRP-1:0]           cfg_edge = '0;
  logic [NGRP-1:0]           clr = '0;
  logic [NGRP-1:0]           irq;
  logic [NGRP*MAXM-1:0]      cause;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  gpio_grp_irq_top #(.NPIN(NPIN), .NGRP(NGRP), .MAXM(MAXM)) u0 (
    .clk(clk), .rst(rst), .gpio_in(gpio), .cfg_sel(cfg_sel), .cfg_pol(cfg_pol),
    .cfg_cnt(cfg_cnt), .cfg_and(cfg_and), .cfg_edge(cfg_edge), .clr(clr),
    .irq_o(irq), .cause_o(cause)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic set_grp(input int g, input bit is_and, input bit is_edge,
                         input int cnt, input logic [7:0] pol);
    for (int m = 0; m < MAXM; m++) begin
      cfg_sel[(g*MAXM+m)*SELW +: SELW] = SELW'(g*MAXM + m);
    end
    cfg_pol[g*MAXM +: MAXM]  = pol;
    cfg_cnt[g*CNTW +: CNTW]  = CNTW'(cnt);
    cfg_and[g]  = is_and;
    cfg_edge[g] = is_edge;
  endtask

  task automatic pulse_clr(input int g);
    clr[g] = 1'b1;
    tick(1);
    clr[g] = 1'b0;
    tick(1);
  endtask

  task automatic settle(input int g);
    tick(6);
    pulse_clr(g);
    tick(1);
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 cause after reset", 32'(cause), 0);
  endtask

  task automatic t_latency();
    set_grp(0, 0, 0, 8, 8'hFF);
    settle(0);
    gpio[2] = 1'b1;
    tick(3);
    chk("R11 irq not yet after 3 edges", 32'(irq[0]), 0);
    tick(1);
    chk("R11 irq after 4 edges", 32'(irq[0]), 1);
    chk("R8 cause slot2", 32'(cause[7:0]), 32'h04);
    gpio[2] = 1'b0;
    tick(6);
    pulse_clr(0);
    chk("R9 irq cleared", 32'(irq[0]), 0);
    chk("R9 cause cleared", 32'(cause[7:0]), 0);
  endtask

  task automatic t_or();
    gpio[5] = 1'b1; gpio[7] = 1'b1;
    tick(6);
    chk("R2 any-member irq", 32'(irq[0]), 1);
    chk("R8 cause slots 5 and 7", 32'(cause[7:0]), 32'hA0);
    gpio[5] = 1'b0; gpio[7] = 1'b0;
    settle(0);
    chk("R9 irq low after or test", 32'(irq[0]), 0);
  endtask

  task automatic t_and();
    set_grp(0, 1, 0, 3, 8'hFF);
    settle(0);
    gpio[0] = 1'b1; gpio[1] = 1'b1;
    tick(6);
    chk("R3 two of three active", 32'(irq[0]), 0);
    gpio[2] = 1'b1;
    tick(6);
    chk("R3 all three active", 32'(irq[0]), 1);
    chk("R8 cause all counted", 32'(cause[7:0]), 32'h07);
    gpio[2:0] = '0;
    settle(0);
  endtask

  task automatic t_pol();
    gpio[0] = 1'b1;
    set_grp(0, 0, 0, 2, 8'hFE);
    settle(0);
    chk("R4 low-active slot idle high", 32'(irq[0]), 0);
    gpio[0] = 1'b0;
    tick(6);
    chk("R4 low-active slot driven low", 32'(irq[0]), 1);
    chk("R4 cause slot0", 32'(cause[7:0]), 32'h01);
    gpio[0] = 1'b1;
    settle(0);
    gpio[1] = 1'b1;
    tick(6);
    chk("R4 high-active slot1", 32'(irq[0]), 1);
    chk("R4 cause slot1", 32'(cause[7:0]), 32'h02);
    gpio[1] = 1'b0;
    settle(0);
    gpio[0] = 1'b0;
  endtask

  task automatic t_count();
    set_grp(0, 0, 0, 2, 8'hFF);
    settle(0);
    gpio[5] = 1'b1;
    tick(6);
    chk("R5 slot beyond count ignored in any-member", 32'(irq[0]), 0);
    chk("R5 no cause beyond count", 32'(cause[7:0]), 0);
    gpio[5] = 1'b0;
    set_grp(0, 1, 0, 0, 8'hFF);
    gpio[7:0] = 8'hFF;
    tick(6);
    chk("R5 empty group silent", 32'(irq[0]), 0);
    gpio[7:0] = 8'h00;
    set_grp(0, 1, 0, 2, 8'hFF);
    settle(0);
    gpio[1:0] = 2'b11;
    tick(6);
    chk("R5 slots beyond count neutral in all-members", 32'(irq[0]), 1);
    chk("R5 cause only counted", 32'(cause[7:0]), 32'h03);
    gpio[1:0] = 2'b00;
    settle(0);
  endtask

  task automatic t_edge();
    set_grp(0, 0, 1, 8, 8'hFF);
    settle(0);
    gpio[3] = 1'b1;
    tick(6);
    chk("R6 edge sets flag", 32'(irq[0]), 1);
    pulse_clr(0);
    tick(3);
    chk("R6 no re-set while held", 32'(irq[0]), 0);
    gpio[3] = 1'b0;
    tick(6);
    gpio[3] = 1'b1;
    tick(6);
    chk("R6 new edge sets again", 32'(irq[0]), 1);
    gpio[3] = 1'b0;
    settle(0);
  endtask

  task automatic t_level();
    set_grp(0, 0, 0, 8, 8'hFF);
    settle(0);
    gpio[4] = 1'b1;
    tick(6);
    pulse_clr(0);
    chk("R7 level flag holds through clear", 32'(irq[0]), 1);
    chk("R7 cause kept", 32'(cause[7:0]), 32'h10);
    gpio[4] = 1'b0;
    settle(0);
    chk("R9 level flag clears once idle", 32'(irq[0]), 0);
  endtask

  task automatic t_groups();
    set_grp(0, 1, 0, 8, 8'hFF);
    set_grp(1, 0, 0, 8, 8'hFF);
    settle(0);
    settle(1);
    gpio[9] = 1'b1;
    tick(6);
    chk("R10 only group1 fires", 32'(irq), 32'h2);
    chk("R10 group1 cause", 32'(cause[15:8]), 32'h02);
    chk("R10 group0 cause untouched", 32'(cause[7:0]), 0);
    gpio[9] = 1'b0;
    tick(6);
    pulse_clr(0);
    chk("R10 clear of group0 leaves group1", 32'(irq), 32'h2);
    pulse_clr(1);
    chk("R10 group1 cleared", 32'(irq), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    tick(4);
    chk("R1 irq during reset", 32'(irq), 0);
    rst = 1'b0;
    tick(1);
    t_reset();
    t_latency();
    t_or();
    t_and();
    t_pol();
    t_count();
    t_edge();
    t_level();
    t_groups();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule